// File: doc/BRIEF.md
# Store Miss Merging Buffer

This buffer sits between a write-back data cache and the system bus and holds store misses that are still outstanding, one entry per 32-byte line. A store that misses takes an entry and records its line address, its byte enables and its data. Later store misses to the same line are folded into that entry straight away, so they never wait for the line to arrive. An entry retires after a programmable quiet period or as soon as all 32 of its bytes have been written.

When an entry retires, the buffer asks the bus for one of two transaction types. A partly written line is read from memory. A fully written line only needs an address-only ownership transaction, because no memory data would survive the merge. When the bus reports completion, the buffer hands the merged line to the cache fill port and frees the entry. The buffer also reports loads that hit a pending line, so that the load pipeline can retry them.

Top module: `store_merge_buf`

## Requirements
- R1: A store miss (`st_valid` high, not stalled) to a line with no open entry takes a free entry. A store of 2^`st_size` bytes at byte address A covers line `A[ADDR_W-1:5]`, bytes `A[4:0]` upward. Byte k of `st_data` goes to line byte `A[4:0]+k`.
- R2: A store to a line that has an open (not yet granted) entry merges into that entry in the same cycle and does not stall, even when every entry is occupied.
- R3: When the entry's byte mask is all ones, the request carries `bus_claim`=1 (address-only ownership). The fill line then equals the stored bytes, and `bus_rdata` is ignored.
- R4: When the mask is not full, the request carries `bus_claim`=0 (line read). Each fill byte is the stored byte where one was written, and otherwise the `bus_rdata` byte. Byte j sits at bits 8j+7:8j.
- R5: `st_stall` is high exactly when a valid store targets a line with no open entry while all ENTRIES entries are occupied. A stalled store is discarded.
- R6: With the bus idle, `bus_req` rises on the (`idle_limit`+1)-th rising edge after the edge that took an entry's last store. A full mask makes it rise on the first such edge.
- R7: Among the eligible entries, the one allocated earliest is requested first, whatever its slot index.
- R8: Once an entry is granted, no store merges into it. A new store to that line takes a fresh entry, which later makes its own request.
- R9: On the rising edge that samples `bus_done`, the buffer frees the entry. For that one cycle it drives `fill_valid` high, together with `fill_addr` (the line address) and `fill_data`.
- R10: `ld_conflict` is high when `ld_valid` is high and `ld_line` matches any occupied entry, whether open or granted.
- R11: Only one bus transaction is in flight at a time. While `bus_req` is high without `bus_gnt`, the request stays high and `bus_addr` stays stable.
- R12: After reset, `bus_req`, `fill_valid`, `st_stall` and `ld_conflict` are low and all entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | IDLE_W | Quiet cycles before a partial entry retires |
| st_valid | input | 1 | Store miss valid |
| st_addr | input | ADDR_W | Store byte address, naturally aligned |
| st_size | input | SZ_W | Store size, 2^n bytes |
| st_data | input | 8*ST_BYTES | Store data, byte 0 lowest |
| st_stall | output | 1 | Store not taken, retry |
| ld_valid | input | 1 | Load probe valid |
| ld_line | input | ADDR_W-5 | Load line address |
| ld_conflict | output | 1 | Load hits a pending line |
| bus_req | output | 1 | Bus request |
| bus_claim | output | 1 | 1 = address-only ownership, 0 = line read |
| bus_addr | output | ADDR_W-5 | Requested line address |
| bus_gnt | input | 1 | Bus grant |
| bus_done | input | 1 | Transaction complete |
| bus_rdata | input | 256 | Read data, valid with bus_done |
| fill_valid | output | 1 | Fill strobe |
| fill_addr | output | ADDR_W-5 | Fill line address |
| fill_data | output | 256 | Merged line |

## Verification
The assertions watch the bus handshake on every cycle: a request stays stable until it is granted, an ownership request never falls back to a read, and fills occur only as single-cycle pulses that follow a completion. On every cycle they also check that a stall happens only with all entries occupied and that a conflict appears only with a load present. Only the bench scenarios can show that merged bytes take priority over read data, that the retire timing follows `idle_limit`, that the oldest eligible entry is chosen from a higher slot, and that a store to a granted line reopens the line in a second entry.

// File: rtl/store_merge_buf.sv
`timescale 1ns/100ps
module store_merge_buf #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 32,
  parameter int IDLE_W     = 8,
  parameter int ST_BYTES   = 8,
  parameter int LINE_BYTES = 32,
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int LA_W  = ADDR_W - OFS_W,
  localparam int LINE_W = 8 * LINE_BYTES,
  localparam int SZ_W  = $clog2($clog2(ST_BYTES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SZ_W-1:0]   st_size,
  input  logic [8*ST_BYTES-1:0] st_data,
  output logic              st_stall,
  input  logic              ld_valid,
  input  logic [LA_W-1:0]   ld_line,
  output logic              ld_conflict,
  output logic              bus_req,
  output logic              bus_claim,
  output logic [LA_W-1:0]   bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [LINE_W-1:0] bus_rdata,
  output logic              fill_valid,
  output logic [LA_W-1:0]   fill_addr,
  output logic [LINE_W-1:0] fill_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [1:0] {B_IDLE, B_REQ, B_WAIT} bst_t;

  logic [ENTRIES-1:0]                 vld, gntd;
  logic [ENTRIES-1:0][LA_W-1:0]       line_q;
  logic [ENTRIES-1:0][LINE_BYTES-1:0] mask_q;
  logic [ENTRIES-1:0][LINE_W-1:0]     data_q;
  logic [ENTRIES-1:0][IDLE_W-1:0]     idle_q;
  logic [ENTRIES-1:0][IDX_W-1:0]      age_q;
  bst_t             bst;
  logic [IDX_W-1:0] sel_q;

  logic [LA_W-1:0]       st_line;
  logic [OFS_W-1:0]      st_ofs;
  logic [OFS_W:0]        st_nb;
  logic [LINE_BYTES-1:0] st_be;
  logic [LINE_W-1:0]     st_wd;
  logic [ENTRIES-1:0]    hit, elig, ld_hit;
  logic                  hit_any, free_any, cand_any, st_acc, alloc, retire;
  logic [IDX_W-1:0]      hit_idx, free_idx, cand_idx;

  assign st_line = st_addr[ADDR_W-1:OFS_W];
  assign st_ofs  = st_addr[OFS_W-1:0];
  assign st_nb   = (OFS_W+1)'(1) << st_size;
  assign st_be   = ((LINE_BYTES'(1) << st_nb) - LINE_BYTES'(1)) << st_ofs;
  assign st_wd   = LINE_W'(st_data) << {st_ofs, 3'b000};

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hit[i]    = vld[i] && !gntd[i] && (line_q[i] == st_line);
      ld_hit[i] = vld[i] && (line_q[i] == ld_line);
      elig[i]   = vld[i] && !gntd[i] && ((&mask_q[i]) || (idle_q[i] >= idle_limit));
    end
  end

  always_comb begin
    hit_any = 1'b0; hit_idx = '0; free_any = 1'b0; free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (hit[i])  begin hit_any  = 1'b1; hit_idx  = IDX_W'(i); end
      if (!vld[i]) begin free_any = 1'b1; free_idx = IDX_W'(i); end
    end
  end

  always_comb begin
    cand_any = 1'b0; cand_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (elig[i] && (!cand_any || age_q[i] > age_q[cand_idx])) begin
        cand_any = 1'b1; cand_idx = IDX_W'(i);
      end
  end

  assign st_stall    = st_valid && !hit_any && !free_any;
  assign st_acc      = st_valid && !st_stall;
  assign alloc       = st_acc && !hit_any;
  assign retire      = (bst == B_WAIT) && bus_done;
  assign ld_conflict = ld_valid && |ld_hit;
  assign bus_req     = (bst == B_REQ);
  assign bus_addr    = line_q[sel_q];
  assign bus_claim   = &mask_q[sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; gntd <= '0; line_q <= '0; mask_q <= '0; data_q <= '0;
      idle_q <= '0; age_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc && free_idx == IDX_W'(i)) begin
          vld[i] <= 1'b1; gntd[i] <= 1'b0; line_q[i] <= st_line;
          mask_q[i] <= st_be; idle_q[i] <= '0; age_q[i] <= '0;
          for (int b = 0; b < LINE_BYTES; b++)
            data_q[i][8*b +: 8] <= st_be[b] ? st_wd[8*b +: 8] : 8'h00;
        end else begin
          if (vld[i])
            age_q[i] <= age_q[i] + IDX_W'(alloc)
                      - IDX_W'(retire && age_q[i] > age_q[sel_q]);
          if (st_acc && hit_any && hit_idx == IDX_W'(i)) begin
            mask_q[i] <= mask_q[i] | st_be;
            idle_q[i] <= '0;
            for (int b = 0; b < LINE_BYTES; b++)
              if (st_be[b]) data_q[i][8*b +: 8] <= st_wd[8*b +: 8];
          end else if (vld[i] && idle_q[i] != '1) begin
            idle_q[i] <= idle_q[i] + 1'b1;
          end
          if (bst == B_REQ && bus_gnt && sel_q == IDX_W'(i)) gntd[i] <= 1'b1;
          if (retire && sel_q == IDX_W'(i)) begin vld[i] <= 1'b0; gntd[i] <= 1'b0; end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bst <= B_IDLE; sel_q <= '0;
    end else begin
      case (bst)
        B_IDLE: if (cand_any) begin sel_q <= cand_idx; bst <= B_REQ; end
        B_REQ:  if (bus_gnt)  bst <= B_WAIT;
        B_WAIT: if (bus_done) bst <= B_IDLE;
        default: bst <= B_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid <= 1'b0; fill_addr <= '0; fill_data <= '0;
    end else begin
      fill_valid <= retire;
      if (retire) begin
        fill_addr <= line_q[sel_q];
        for (int b = 0; b < LINE_BYTES; b++)
          fill_data[8*b +: 8] <= mask_q[sel_q][b] ? data_q[sel_q][8*b +: 8]
                                                  : bus_rdata[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/smb_checker.sv
`timescale 1ns/100ps
module smb_checker #(
  parameter int ENTRIES = 4,
  parameter int LA_W    = 27
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_stall,
  input logic [ENTRIES-1:0] vld,
  input logic               bus_req,
  input logic               bus_gnt,
  input logic               bus_claim,
  input logic [LA_W-1:0]    bus_addr,
  input logic               bus_done,
  input logic               fill_valid,
  input logic               ld_valid,
  input logic               ld_conflict
);
  p_stall_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_stall |-> (&vld));
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr)));
  p_claim_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_claim && !bus_gnt) |=> bus_claim);
  p_fill_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(bus_done));
  p_fill_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !fill_valid);
  p_conflict_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_conflict |-> ld_valid);
endmodule

bind store_merge_buf smb_checker #(.ENTRIES(ENTRIES), .LA_W(LA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .st_stall(st_stall), .vld(vld),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_claim(bus_claim),
  .bus_addr(bus_addr), .bus_done(bus_done), .fill_valid(fill_valid),
  .ld_valid(ld_valid), .ld_conflict(ld_conflict)
);

// File: tb/store_merge_buf_tb_top.sv
`timescale 1ns/100ps
module store_merge_buf_tb_top;
  localparam int N = 4, AW = 32, IW = 8, LA = AW - 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [IW-1:0] idle_limit = '0;
  logic st_valid = 0, ld_valid = 0, bus_gnt = 0, bus_done = 0;
  logic [AW-1:0] st_addr = '0;
  logic [1:0] st_size = '0;
  logic [63:0] st_data = '0;
  logic [LA-1:0] ld_line = '0;
  logic [255:0] bus_rdata = '0;
  logic st_stall, ld_conflict, bus_req, bus_claim, fill_valid;
  logic [LA-1:0] bus_addr, fill_addr;
  logic [255:0] fill_data;

  store_merge_buf dut_i (.clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .st_stall(st_stall), .ld_valid(ld_valid), .ld_line(ld_line),
    .ld_conflict(ld_conflict), .bus_req(bus_req), .bus_claim(bus_claim),
    .bus_addr(bus_addr), .bus_gnt(bus_gnt), .bus_done(bus_done),
    .bus_rdata(bus_rdata), .fill_valid(fill_valid), .fill_addr(fill_addr),
    .fill_data(fill_data));

  int compared = 0, mismatched = 0;
  bit g_auto = 0;

  logic          mv [N], mg [N];
  logic [LA-1:0] ml [N];
  logic [31:0]   mm [N];
  logic [255:0]  md [N];
  int fly = -1;
  bit pend = 0;
  logic [LA-1:0] pend_addr;
  logic [255:0] pend_data;

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  function automatic int find_open(logic [LA-1:0] l);
    for (int i = 0; i < N; i++) if (mv[i] && !mg[i] && ml[i] == l) return i;
    return -1;
  endfunction

  function automatic int used();
    int c = 0;
    for (int i = 0; i < N; i++) if (mv[i]) c++;
    return c;
  endfunction

  task automatic step();
    int gi, si;
    bit es, ec;
    logic [31:0] be;
    #1;
    if (g_auto) begin
      bus_gnt = bus_req && ($urandom % 3 == 0);
      bus_done = (fly >= 0) && ($urandom % 4 == 0);
      bus_rdata = rnd256();
    end
    #1;
    if (pend) begin
      chk("R9 fill_valid", 256'(fill_valid), 256'(1));
      chk("R9 fill_addr", 256'(fill_addr), 256'(pend_addr));
      chk("R4 fill_data", fill_data, pend_data);
    end else chk("R9 no fill", 256'(fill_valid), 256'(0));
    pend = 0;
    es = st_valid && find_open(st_addr[AW-1:5]) < 0 && used() == N;
    chk("R5 st_stall", 256'(st_stall), 256'(es));
    ec = 0;
    for (int i = 0; i < N; i++) if (mv[i] && ml[i] == ld_line) ec = ld_valid;
    chk("R10 ld_conflict", 256'(ld_conflict), 256'(ec));
    gi = -1;
    if (bus_req && bus_gnt) begin
      gi = find_open(bus_addr);
      chk("R11 granted line pending", 256'(gi >= 0), 256'(1));
      if (gi >= 0) chk("R3 bus_claim", 256'(bus_claim), 256'(mm[gi] == '1));
    end
    if (st_valid && !es) begin
      si = find_open(st_addr[AW-1:5]);
      if (si < 0) begin
        for (int i = N-1; i >= 0; i--) if (!mv[i]) si = i;
        mv[si] = 1; mg[si] = 0; ml[si] = st_addr[AW-1:5]; mm[si] = '0; md[si] = '0;
      end
      be = ((32'd1 << (32'd1 << st_size)) - 32'd1) << st_addr[4:0];
      for (int b = 0; b < 32; b++)
        if (be[b]) md[si][8*b +: 8] = 8'(st_data >> (8*(b - int'(st_addr[4:0]))));
      mm[si] |= be;
    end
    if (gi >= 0) begin mg[gi] = 1; fly = gi; end
    if (bus_done && fly >= 0) begin
      pend = 1; pend_addr = ml[fly];
      for (int b = 0; b < 32; b++)
        pend_data[8*b +: 8] = mm[fly][b] ? md[fly][8*b +: 8] : bus_rdata[8*b +: 8];
      mv[fly] = 0; mg[fly] = 0; fly = -1;
    end
    @(negedge clk);
  endtask

  task automatic store(logic [LA-1:0] l, logic [4:0] ofs, logic [1:0] sz, logic [63:0] d);
    st_valid = 1; st_addr = {l, ofs}; st_size = sz; st_data = d;
    step();
    st_valid = 0;
  endtask

  task automatic fill_line(logic [LA-1:0] l);
    for (int q = 0; q < 4; q++) store(l, 5'(8*q), 2'd3, {$urandom, $urandom});
  endtask

  task automatic wait_req();
    for (int k = 0; k < 300 && !bus_req; k++) step();
  endtask

  task automatic grant();
    bus_gnt = 1; step(); bus_gnt = 0;
  endtask

  task automatic done();
    bus_rdata = rnd256(); bus_done = 1; step(); bus_done = 0;
  endtask

  task automatic drain();
    g_auto = 1; idle_limit = 0;
    for (int k = 0; k < 2000 && (used() != 0 || pend); k++) step();
    g_auto = 0; bus_gnt = 0; bus_done = 0;
    chk("R9 drained", 256'(used()), 256'(0));
  endtask

  initial begin
    #500000;
    mismatched++; compared++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0071));
    for (int i = 0; i < N; i++) begin mv[i] = 0; mg[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 bus_req", 256'(bus_req), 256'(0));
    chk("R12 fill_valid", 256'(fill_valid), 256'(0));
    chk("R12 st_stall", 256'(st_stall), 256'(0));
    chk("R12 ld_conflict", 256'(ld_conflict), 256'(0));

    // R6: partial entry retires after idle_limit quiet cycles
    idle_limit = 4;
    store(27'h40, 5'd4, 2'd2, 64'hdead_beef);
    for (int m = 0; m <= 5; m++) begin
      chk("R6 idle timing", 256'(bus_req), 256'(m >= 5));
      if (m < 5) step();
    end
    chk("R4 read kind", 256'(bus_claim), 256'(0));
    grant(); done(); step();

    // R6 full mask: request one edge after the completing store
    idle_limit = 200;
    fill_line(27'h41);
    chk("R6 full immediate", 256'(bus_req), 256'(0));
    step();
    chk("R6 full immediate", 256'(bus_req), 256'(1));
    chk("R3 claim kind", 256'(bus_claim), 256'(1));
    grant(); done(); step();

    // R5 / R2: stall on new line with all entries in use, merge still allowed
    for (int i = 0; i < N; i++) store(27'h50 + 27'(i), 5'd0, 2'd0, 64'(i + 1));
    store(27'h60, 5'd0, 2'd0, 64'h77);
    chk("R5 stall seen", 256'(used()), 256'(N));
    store(27'h51, 5'd8, 2'd3, 64'h1122_3344_5566_7788);
    ld_valid = 1; ld_line = 27'h52; step();
    ld_line = 27'h61; step(); ld_valid = 0;
    drain();

    // R7: oldest eligible entry wins over lower slot index
    idle_limit = 0;
    fill_line(27'h70);
    grant();
    store(27'h71, 5'd2, 2'd1, 64'hbbbb);
    store(27'h72, 5'd6, 2'd1, 64'hcccc);
    done();
    wait_req();
    chk("R7 oldest first", 256'(bus_addr), 256'(27'h71));
    grant();
    store(27'h73, 5'd9, 2'd0, 64'hdd);
    done();
    wait_req();
    chk("R7 oldest not lowest slot", 256'(bus_addr), 256'(27'h72));
    grant(); done();
    wait_req();
    chk("R7 newest last", 256'(bus_addr), 256'(27'h73));
    grant(); done(); step();

    // R8 / R10: store to a granted line opens a new entry
    idle_limit = 200;
    fill_line(27'h80);
    wait_req(); grant();
    store(27'h80, 5'd16, 2'd1, 64'h5a5a);
    ld_valid = 1; ld_line = 27'h80; step(); ld_valid = 0;
    done(); step();
    idle_limit = 0;
    wait_req();
    chk("R8 reopened line", 256'(bus_addr), 256'(27'h80));
    chk("R8 reopened partial", 256'(bus_claim), 256'(0));
    grant(); done(); step();

    // R1..R11 random mix
    g_auto = 1;
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0) idle_limit = IW'($urandom % 8);
      ld_valid = ($urandom % 2 == 0); ld_line = 27'h90 + 27'($urandom % 6);
      if ($urandom % 16 == 0) begin
        fill_line(27'h90 + 27'($urandom % 6));
      end else if ($urandom % 2 == 0) begin
        st_size = 2'($urandom % 4);
        store(27'h90 + 27'($urandom % 6), 5'(($urandom % 32) & ~((1 << st_size) - 1)),
              st_size, {$urandom, $urandom});
      end else step();
    end
    ld_valid = 0;
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule